// File: doc/BRIEF.md
# Multicart PRG Bank Switching Mapper

This block is the program-ROM bank logic of a multi-game cartridge for an 8-bit game console. The console CPU writes into the cartridge ROM window at $8000-$FFFF. Two write-only registers latch those writes:

- The **outer register** holds the 3-bit game-group bank, the 16/32 KB size bit and the nametable mirroring bit.
- The **inner register** holds a 3-bit sub-bank and a bit that chooses between switchable-low-window and fixed-size layouts.

The two address decodes overlap. A write that falls in $8000-$9FFF loads both registers at the same moment.

From the two registers the mapper forms a 6-bit 16 KB bank for each CPU window. It drives that bank onto ROM address lines A19-A14, choosing the window with CPU A14. CPU A13-A0 go straight to the ROM and do not pass through this block. The mapper also steers the console's internal nametable RAM A10 line from either PPU A10 or PPU A11. Character memory is a fixed RAM and needs no banking.

A register load is taken when the CPU phase-2 clock falls during a write with ROM select active. All of these inputs are sampled in the system clock domain. Only the power-on reset clears the registers; a console reset does not reach this block.

Top module: `mc_prg_mapper`

## Requirements
- R1: A write with `romsel_n` low and `cpu_a14_13` equal to 00 or 01 ($8000-$BFFF) loads the outer register. The outer register keeps bit 7 as mirroring (0 vertical, 1 horizontal), bit 6 as size mode (1 = 32 KB), and bits 0, 5 and 4 as the outer bank.
- R2: A write with `cpu_a14_13` equal to 00 or 10 ($8000-$9FFF, $C000-$DFFF) loads the inner register from data bits 3:0. Bit 3 is the layout bit and bits 2:0 are the inner bank. A write at 00 therefore loads both registers with the same byte.
- R3: These leave both registers unchanged:
  - writes at `cpu_a14_13` = 11 ($E000-$FFFF);
  - read cycles;
  - write cycles with `romsel_n` high.
- R4: A load uses the address and data present in the system-clock cycle where `m2` is first seen low after being high. It is visible on `prg_a_hi` one clock later. Data that changes after that cycle has no effect, and no load happens while `m2` stays high.
- R5: `prg_a_hi[5:3]` (A19-A17) always equals the outer bank taken from data bits {D0, D5, D4}, in that order from high to low.
- R6: Mode {layout bit, size bit} = 00: the $8000 window (A14 = 0) gives {outer, inner}, and the $C000 window gives {outer, 111}.
- R7: Mode 01: the $8000 window gives {outer, inner[2:1], 0}, and the $C000 window gives {outer, 111}.
- R8: Mode 10: both windows give {outer, inner}.
- R9: Mode 11: the $8000 window gives {outer, inner[2:1], 0}, and the $C000 window gives {outer, inner[2:1], 1}.
- R10: `ciram_a10` follows `ppu_a10` when the mirroring bit is 0 and `ppu_a11` when it is 1.
- R11: `rst_n` low at a clock edge clears both registers. Afterwards the $8000 window gives bank 0, the $C000 window gives bank 7, and mirroring is vertical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all bus inputs |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| m2 | input | 1 | CPU phase-2 clock; its falling edge commits a write |
| cpu_rw | input | 1 | CPU read/write strobe, 1 = read |
| romsel_n | input | 1 | ROM select, active low, marks the $8000-$FFFF range |
| cpu_a14_13 | input | 2 | CPU address bits A14 and A13 |
| cpu_data | input | 8 | CPU data bus |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_a_hi | output | 6 | ROM address lines A19-A14 |
| ciram_a10 | output | 1 | Nametable RAM A10 select |

## Verification
The bench targets the overlapped decode.
- A write at $8000 must move both registers. A design that decoded the inner register from A14 alone would miss this.
- Writes at $A000 and $C000 must each move only one register.
- Writes to $E000, reads, and writes with ROM select high must leave every output unchanged. A decoder that also accepted $E000 would show a changed inner bank.

The forced low bit in modes 01 and 11 is checked with odd inner banks. There a missing mask shows up as an odd bank in the $8000 window, or an even bank in the $C000 window in 32 KB mode.

The scrambled outer bit order {D0, D5, D4} is checked with single-bit data patterns, so a plain slice of D2:D0 gives a visibly wrong A19-A17.

Each write also checks that nothing changes before the `m2` fall. Corrupting the data right after the fall would expose a latch that samples late. Finally, a power-on reset in mid-run must return the fixed 0/7 bank pair.

// File: rtl/mc_pkg.sv
// Package: shared types and widths for the multicart PRG mapper.
// Assumes the 16 KB bank number is outer bank bits followed by inner bank bits.
package mc_pkg;

    localparam int OUTER_W = 3;                  // outer (game group) bank width
    localparam int INNER_W = 3;                  // inner (sub) bank width
    localparam int BANK_W  = OUTER_W + INNER_W;  // full 16 KB bank number width
    localparam int NUM_WIN = 2;                  // CPU windows: $8000 and $C000

    // Mode index is {inner layout bit, outer size bit}.
    typedef enum logic [1:0] {
        MODE_SPLIT      = 2'b00,  // low window switchable, high window fixed last
        MODE_SPLIT_EVEN = 2'b01,  // as above with the low bank forced even
        MODE_MIRROR16   = 2'b10,  // same 16 KB bank in both windows
        MODE_WIDE32     = 2'b11   // one 32 KB bank across both windows
    } prg_mode_e;

    // CPU address window from A14:A13 inside the ROM range.
    typedef enum logic [1:0] {
        WIN_8000 = 2'b00,
        WIN_A000 = 2'b01,
        WIN_C000 = 2'b10,
        WIN_E000 = 2'b11
    } cpu_win_e;

    // Fields kept from the outer register.
    typedef struct packed {
        logic               mirror_h;   // 1 = horizontal mirroring
        logic               wide;       // 1 = 32 KB size mode
        logic [OUTER_W-1:0] outer_bank; // {D0, D5, D4}
    } outer_t;

    // Fields kept from the inner register.
    typedef struct packed {
        logic               layout;     // 1 = fixed-size layout
        logic [INNER_W-1:0] inner_bank;
    } inner_t;

endpackage

// File: rtl/mc_bus_decode.sv
// Module: mc_bus_decode
// Finds the falling edge of the CPU phase-2 clock in the system clock domain.
// On that edge, turns a ROM-range write into per-register load strobes.
// Assumes m2, cpu_rw, romsel_n, the address and the data are already
// synchronous to clk and stable in the cycle where m2 is first seen low.
module mc_bus_decode
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m2,
    input  logic       cpu_rw,
    input  logic       romsel_n,
    input  logic [1:0] win_i,
    output logic       ld_outer_o,
    output logic       ld_inner_o
);

    logic     m2_q;
    logic     m2_fall;
    logic     wr_commit;
    cpu_win_e win;

    // Purpose: remember the previous m2 level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m2_q <= 1'b0;
        end else begin
            m2_q <= m2;
        end
    end

    // Purpose: qualify the m2 fall with a ROM-range write cycle.
    always_comb begin
        m2_fall   = m2_q & ~m2;
        wr_commit = m2_fall & ~cpu_rw & ~romsel_n;
    end

    // Purpose: map the CPU window onto the two overlapping register decodes.
    always_comb begin
        win        = cpu_win_e'(win_i);
        ld_outer_o = 1'b0;
        ld_inner_o = 1'b0;
        unique case (win)
            WIN_8000: begin
                ld_outer_o = wr_commit;
                ld_inner_o = wr_commit;
            end
            WIN_A000: ld_outer_o = wr_commit;
            WIN_C000: ld_inner_o = wr_commit;
            WIN_E000: begin
                ld_outer_o = 1'b0;
                ld_inner_o = 1'b0;
            end
            default: begin
                ld_outer_o = 1'b0;
                ld_inner_o = 1'b0;
            end
        endcase
    end

    // R4: any load strobe needs m2 high in the previous cycle and low now.
    assert_load_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_outer_o || ld_inner_o) |-> ($past(m2) && !m2));

    // R3: reads never produce a load strobe.
    assert_no_load_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rw |-> !(ld_outer_o || ld_inner_o));

    // R3: the $E000-$FFFF window loads nothing.
    assert_top_window_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i == 2'b11) |-> !(ld_outer_o || ld_inner_o));

endmodule

// File: rtl/mc_bank_regs.sv
// Module: mc_bank_regs
// Holds the outer and inner bank registers and loads them on their strobes.
// Keeps only the outer register bits that the banking and mirroring use.
// Assumes the strobes are single-cycle and that data_i is valid in that cycle.
module mc_bank_regs
    import mc_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_outer_i,
    input  logic              ld_inner_i,
    input  logic [DATA_W-1:0] data_i,
    output outer_t            outer_o,
    output inner_t            inner_o
);

    localparam int INNER_FIELD_W = INNER_W + 1;

    outer_t outer_q;
    inner_t inner_q;
    outer_t outer_d;
    inner_t inner_d;

    // Purpose: split the data byte into the fields each register keeps.
    always_comb begin
        outer_d.mirror_h   = data_i[7];
        outer_d.wide       = data_i[6];
        outer_d.outer_bank = {data_i[0], data_i[5], data_i[4]};
        inner_d            = inner_t'(data_i[INNER_FIELD_W-1:0]);
    end

    // Purpose: outer register, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outer_q <= '0;
        end else if (ld_outer_i) begin
            outer_q <= outer_d;
        end
    end

    // Purpose: inner register, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_q <= '0;
        end else if (ld_inner_i) begin
            inner_q <= inner_d;
        end
    end

    assign outer_o = outer_q;
    assign inner_o = inner_q;

    // R3: without a strobe the outer register holds its value.
    assert_outer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_outer_i |=> $stable(outer_q));

    // R3: without a strobe the inner register holds its value.
    assert_inner_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_inner_i |=> $stable(inner_q));

    // R1: an outer load captures bit 7, bit 6 and the scrambled bank order.
    assert_outer_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_outer_i |=> (outer_q.mirror_h == $past(data_i[7]) &&
                        outer_q.wide == $past(data_i[6]) &&
                        outer_q.outer_bank == {$past(data_i[0]), $past(data_i[5]), $past(data_i[4])}));

    // R2: an inner load captures data bits 3:0.
    assert_inner_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_inner_i |=> (inner_q == $past(data_i[INNER_FIELD_W-1:0])));

endmodule

// File: rtl/mc_bank_select.sv
// Module: mc_bank_select
// Forms the 16 KB bank number for each CPU window from the register fields.
// Then selects the bank for the current access with CPU A14.
// Purely combinational; clk and rst_n only qualify the assertions.
module mc_bank_select
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  outer_t            outer_i,
    input  inner_t            inner_i,
    input  logic              a14_i,
    output logic [BANK_W-1:0] bank_o
);

    localparam logic [INNER_W-1:0] LAST_INNER = '1;

    prg_mode_e         mode;
    logic [BANK_W-1:0] win_bank [NUM_WIN];

    // Purpose: mode index from the layout bit and the size bit.
    always_comb begin
        mode = prg_mode_e'({inner_i.layout, outer_i.wide});
    end

    // One bank former per CPU window; w = 0 is $8000, w = 1 is $C000.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [INNER_W-1:0] low_part;

        // Purpose: inner part of the bank for this window in the active mode.
        always_comb begin
            low_part = inner_i.inner_bank;
            unique case (mode)
                MODE_SPLIT:      low_part = (w == 0) ? inner_i.inner_bank : LAST_INNER;
                MODE_SPLIT_EVEN: low_part = (w == 0) ? {inner_i.inner_bank[INNER_W-1:1], 1'b0}
                                                     : LAST_INNER;
                MODE_MIRROR16:   low_part = inner_i.inner_bank;
                MODE_WIDE32:     low_part = {inner_i.inner_bank[INNER_W-1:1], (w == 0) ? 1'b0 : 1'b1};
                default:         low_part = inner_i.inner_bank;
            endcase
            win_bank[w] = {outer_i.outer_bank, low_part};
        end
    end

    // Purpose: choose the window bank for the current CPU access.
    always_comb begin
        bank_o = a14_i ? win_bank[1] : win_bank[0];
    end

    // R6 R7: in the split modes the $C000 window is the last inner bank.
    assert_fixed_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inner_i.layout && a14_i) |-> (bank_o[INNER_W-1:0] == LAST_INNER));

    // R7 R9: with the size bit set, the $8000 window bank is even.
    assert_even_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_i.wide && !a14_i) |-> (bank_o[0] == 1'b0));

    // R9: in 32 KB mode the $C000 window bank is odd.
    assert_odd_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_i.wide && inner_i.layout && a14_i) |-> (bank_o[0] == 1'b1));

    // R8: in mirrored 16 KB mode both windows hold the inner bank.
    assert_mirror_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_i.layout && !outer_i.wide) |-> (bank_o[INNER_W-1:0] == inner_i.inner_bank));

    // R5: the top bank bits are always the outer bank.
    assert_outer_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_o[BANK_W-1:INNER_W] == outer_i.outer_bank);

endmodule

// File: rtl/mc_prg_mapper.sv
// Module: mc_prg_mapper (top)
// Bank-switching mapper for a multi-game cartridge. It decodes CPU writes to
// the ROM range into two overlapping registers and drives ROM A19-A14.
// It also steers the nametable RAM A10 line from PPU A10 or PPU A11.
// Assumes all CPU and PPU inputs are synchronous to clk; rst_n is power-on only.
module mc_prg_mapper
    import mc_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              cpu_rw,
    input  logic              romsel_n,
    input  logic [1:0]        cpu_a14_13,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    output logic [BANK_W-1:0] prg_a_hi,
    output logic              ciram_a10
);

    logic   ld_outer;
    logic   ld_inner;
    outer_t outer_f;
    inner_t inner_f;

    mc_bus_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .m2         (m2),
        .cpu_rw     (cpu_rw),
        .romsel_n   (romsel_n),
        .win_i      (cpu_a14_13),
        .ld_outer_o (ld_outer),
        .ld_inner_o (ld_inner)
    );

    mc_bank_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_outer_i (ld_outer),
        .ld_inner_i (ld_inner),
        .data_i     (cpu_data),
        .outer_o    (outer_f),
        .inner_o    (inner_f)
    );

    mc_bank_select u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .outer_i (outer_f),
        .inner_i (inner_f),
        .a14_i   (cpu_a14_13[1]),
        .bank_o  (prg_a_hi)
    );

    // Purpose: nametable A10 from PPU A11 (horizontal) or PPU A10 (vertical).
    always_comb begin
        ciram_a10 = outer_f.mirror_h ? ppu_a11 : ppu_a10;
    end

    // R10: vertical mirroring passes PPU A10 through.
    assert_mirror_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !outer_f.mirror_h |-> (ciram_a10 == ppu_a10));

    // R10: horizontal mirroring passes PPU A11 through.
    assert_mirror_h_R10: assert property (@(posedge clk) disable iff (!rst_n)
        outer_f.mirror_h |-> (ciram_a10 == ppu_a11));

endmodule

// File: tb/tb_mc_prg_mapper.sv
module tb_mc_prg_mapper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m2 = 1'b0;
    logic       cpu_rw = 1'b1;
    logic       romsel_n = 1'b1;
    logic [1:0] cpu_a14_13 = 2'b00;
    logic [7:0] cpu_data = 8'h00;
    logic       ppu_a10 = 1'b0;
    logic       ppu_a11 = 1'b0;
    logic [5:0] prg_a_hi;
    logic       ciram_a10;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model of the two registers, full byte / nibble.
    logic [7:0] m_outer = 8'h00;
    logic [3:0] m_inner = 4'h0;

    always #10 clk = ~clk;

    mc_prg_mapper dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .m2         (m2),
        .cpu_rw     (cpu_rw),
        .romsel_n   (romsel_n),
        .cpu_a14_13 (cpu_a14_13),
        .cpu_data   (cpu_data),
        .ppu_a10    (ppu_a10),
        .ppu_a11    (ppu_a11),
        .prg_a_hi   (prg_a_hi),
        .ciram_a10  (ciram_a10)
    );

    // Expected 16 KB bank from the mode table in the requirements.
    function automatic logic [5:0] exp_bank(input logic [7:0] o, input logic [3:0] i, input logic hi);
        logic [2:0] pp;
        logic [2:0] q;
        pp = {o[0], o[5], o[4]};
        q  = i[2:0];
        case ({i[3], o[6]})
            2'b00:   return hi ? {pp, 3'b111} : {pp, q};
            2'b01:   return hi ? {pp, 3'b111} : {pp, q[2:1], 1'b0};
            2'b10:   return {pp, q};
            default: return hi ? {pp, q[2:1], 1'b1} : {pp, q[2:1], 1'b0};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Look at both windows and the mirroring with random PPU lines.
    task automatic check_state(input string req);
        for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            cpu_rw = 1'b1;
            romsel_n = 1'b0;
            cpu_a14_13 = {w[0], 1'($urandom_range(0, 1))};
            ppu_a10 = 1'($urandom_range(0, 1));
            ppu_a11 = 1'($urandom_range(0, 1));
            #2;
            check(req, prg_a_hi, exp_bank(m_outer, m_inner, w[0]));
            check("R10", ciram_a10, m_outer[7] ? ppu_a11 : ppu_a10);
        end
    endtask

    // One CPU bus cycle ending with an m2 fall; the model follows R1-R3.
    task automatic bus_cycle(input logic [1:0] win, input logic [7:0] d, input logic rw, input logic sel);
        @(negedge clk);
        cpu_a14_13 = win;
        cpu_data = d;
        cpu_rw = rw;
        romsel_n = ~sel;
        m2 = 1'b1;
        @(negedge clk);
        // R4: nothing changes while m2 is still high
        #1;
        check("R4", prg_a_hi, exp_bank(m_outer, m_inner, win[1]));
        m2 = 1'b0;
        @(negedge clk);
        // R4: data changing after the fall must not matter
        cpu_data = ~d;
        cpu_rw = 1'b1;
        romsel_n = 1'b1;
        if (!rw && sel) begin
            if (!win[1]) m_outer = d;
            if (!win[0]) m_inner = d[3:0];
        end
    endtask

    task automatic power_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m2 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_outer = 8'h00;
        m_inner = 4'h0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        power_reset();
        // R11: reset state, bank 0 low, bank 7 high, vertical
        check_state("R11");

        // R2: $8000 write loads both registers
        bus_cycle(2'b00, 8'hFF, 1'b0, 1'b1);
        check_state("R2");
        // R1: $A000 write loads only the outer register
        bus_cycle(2'b01, 8'h15, 1'b0, 1'b1);
        check_state("R1");
        // R2: $C000 write loads only the inner register
        bus_cycle(2'b10, 8'hF3, 1'b0, 1'b1);
        check_state("R2");
        // R3: $E000 write, read cycle and deselected write are ignored
        bus_cycle(2'b11, 8'h0A, 1'b0, 1'b1);
        check_state("R3");
        bus_cycle(2'b00, 8'h5C, 1'b1, 1'b1);
        check_state("R3");
        bus_cycle(2'b10, 8'h06, 1'b0, 1'b0);
        check_state("R3");

        // R5: single-bit patterns through the outer bank order
        bus_cycle(2'b01, 8'h01, 1'b0, 1'b1);
        check_state("R5");
        bus_cycle(2'b01, 8'h20, 1'b0, 1'b1);
        check_state("R5");
        bus_cycle(2'b01, 8'h10, 1'b0, 1'b1);
        check_state("R5");

        // R6 R7 R8 R9: each mode with an odd inner bank
        bus_cycle(2'b00, 8'h35, 1'b0, 1'b1);
        check_state("R6");
        bus_cycle(2'b00, 8'h73, 1'b0, 1'b1);
        check_state("R7");
        bus_cycle(2'b00, 8'h9D, 1'b0, 1'b1);
        check_state("R8");
        bus_cycle(2'b00, 8'hDB, 1'b0, 1'b1);
        check_state("R9");

        // Random mix of windows, directions and selects
        for (int n = 0; n < 400; n++) begin
            bus_cycle(2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                      ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0));
            case ({m_inner[3], m_outer[6]})
                2'b00:   check_state("R6");
                2'b01:   check_state("R7");
                2'b10:   check_state("R8");
                default: check_state("R9");
            endcase
        end

        // R11: power-on reset in mid-run clears both registers
        bus_cycle(2'b00, 8'hFF, 1'b0, 1'b1);
        power_reset();
        check_state("R11");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule